// File: doc/BRIEF.md
# SPI Flash Opcode-Menu Cycle Engine

This block is a register-programmed SPI master that issues one flash command per start request. Software does not send raw bytes. It loads a table of eight one-byte commands, each tagged with a two-bit kind, and then starts a cycle by naming a table slot. The engine frames the chosen command on a single-bit mode-0 SPI link. The frame is the opcode, then three address bytes for the kinds that carry an address, then an optional data phase of up to 64 bytes that moves to or from an internal buffer.

A start request can also ask for an atomic prefix. A one-byte prefix, picked from two stored candidates, then goes out as its own chip-select frame just before the main frame. Nothing can start in between, so a write-enable stays bound to the command it unlocks. A sticky lock freezes the command table, the kind field and the prefixes until reset. All registers are 16-bit words on a simple single-cycle bus with byte enables. The SPI clock is the system clock divided by a fixed parameter.

Top module: `spi_menu_engine`

## Requirements
- R1: The first byte of the main frame is the table entry named by control bits 6:4. The table is bytes 0..7: word 8 holds entries 1:0, word 9 holds 3:2, word 10 holds 5:4 and word 11 holds 7:6, with the lower entry in bits 7:0. The kind of entry i is bits 2i+1:2i of word 5.
- R2: Kinds 2 (read with address) and 3 (write with address) send the 24-bit address right after the opcode, most significant byte first. Word 2 holds address bits 15:0 and word 3 bits 7:0 hold address bits 23:16. Kinds 0 and 1 send no address.
- R3: When control bit 14 is set, the data phase moves (bits 13:8)+1 bytes. Kinds 1 and 3 send buffer bytes from byte 0 upward. Kinds 0 and 2 store the received bytes little-endian from byte 0. Buffer word 32+k holds byte 2k in bits 7:0 and byte 2k+1 in bits 15:8.
- R4: With control bit 14 clear, the frame ends after the opcode and any address bytes, whatever the byte count field holds.
- R5: With control bit 2 set, one prefix byte goes out in its own chip-select frame immediately before the main frame. Control bit 3 picks word 4 bits 15:8 (set) or bits 7:0 (clear).
- R6: Status (word 0) reads 0 after reset. Bit 0 is high while a cycle runs. Bit 2 sets when the cycle ends. Writing 1 to bit 2 or bit 3 clears it.
- R7: Writing 1 to status bit 15 sets a lock that reads back as bit 15 and only reset clears. While it is set, writes to the table, kind and prefix words have no effect.
- R8: A cycle starts only on a control write whose low byte is enabled and has bit 1 set. A write to the high byte alone stores its fields and starts nothing.
- R9: A start request made while a cycle runs is ignored and sets status bit 3. The running frame completes unchanged.
- R10: SPI mode 0: clock low whenever chip select is high, data sampled on the rising edge, and each clock-high phase lasting SCK_DIV system clocks.
- R11: A byte count field of 63 moves all 64 buffer bytes in one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Word address |
| bus_be | input | 2 | Byte enables for the write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| spi_sck | output | 1 | SPI clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A wrong phase or byte index in the sequencer shows at the pins within a single frame, as a missing or extra address byte, a data phase that runs one byte long or short, or a chip-select gap absent between prefix and command. A slip in the bit shifter corrupts the very byte it affects, and a wrong clock-high width is flagged on the first clock pulse. Faults in the buffer index or in the lock and clear logic only surface on the next register read, so the bench reads back buffer words, the table and the status word directly after each cycle.

// File: rtl/spi_menu_pkg.sv
package spi_menu_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PRE,
      PH_GAP,
      PH_OPC,
      PH_ADR,
      PH_DAT
   } phase_t;

   localparam logic [5:0] A_STAT  = 6'd0;
   localparam logic [5:0] A_CTRL  = 6'd1;
   localparam logic [5:0] A_ADRL  = 6'd2;
   localparam logic [5:0] A_ADRH  = 6'd3;
   localparam logic [5:0] A_PREF  = 6'd4;
   localparam logic [5:0] A_KIND  = 6'd5;
   localparam logic [3:0] A_MENU  = 4'b0010;
endpackage

// File: rtl/spi_menu_shift.sv
module spi_menu_shift #(
   parameter int DIV = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   input  logic [7:0] tx,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       done,
   output logic [7:0] rx
);
   logic       active;
   logic [3:0] hc;
   logic [7:0] txq;
   logic       tick;

   generate
      if (DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(DIV);
         localparam logic [DW-1:0] DLAST = DW'(DIV - 1);
         logic [DW-1:0] dc;
         always_ff @(posedge clk) begin
            if (rst || !active || tick) dc <= '0;
            else                        dc <= dc + 1'b1;
         end
         assign tick = (dc == DLAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         hc     <= '0;
         txq    <= '0;
         rx     <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            if (start) begin
               active <= 1'b1;
               txq    <= tx;
               hc     <= '0;
            end
         end else if (tick) begin
            if (!hc[0]) rx <= {rx[6:0], miso};
            hc <= hc + 1'b1;
            if (hc == 4'd15) begin
               active <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

   assign sck  = active & hc[0];
   assign mosi = active & txq[3'd7 - hc[3:1]];

   assert_start_idle_R10: assert property (@(posedge clk) disable iff (rst)
      start |-> !active);
endmodule

// File: rtl/spi_menu_seq.sv
module spi_menu_seq
   import spi_menu_pkg::*;
#(
   parameter int DIV = 2,
   parameter int BW  = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          go,
   input  logic [7:0]    c_opcode,
   input  logic [1:0]    c_kind,
   input  logic [23:0]   c_addr,
   input  logic [BW-1:0] c_last,
   input  logic          c_den,
   input  logic          c_atomic,
   input  logic [7:0]    c_prefix,
   output logic [BW-1:0] buf_ridx,
   input  logic [7:0]    buf_rbyte,
   output logic          buf_we,
   output logic [BW-1:0] buf_widx,
   output logic [7:0]    buf_wbyte,
   output logic          busy,
   output logic          done,
   output logic          cs_n,
   output logic          sh_start,
   output logic [7:0]    sh_tx,
   input  logic          sh_done,
   input  logic [7:0]    sh_rx
);
   localparam int GAP = 2 * DIV;
   localparam int GW  = $clog2(GAP + 1);
   localparam logic [GW-1:0] GLAST = GW'(GAP - 1);
   localparam logic [BW-1:0] ALAST = BW'(2);

   phase_t        phase;
   logic [7:0]    opc_q;
   logic [1:0]    kind_q;
   logic [23:0]   addr_q;
   logic [BW-1:0] last_q;
   logic          den_q;
   logic [BW-1:0] idx;
   logic [GW-1:0] gap;
   logic [7:0]    data_tx;

   assign busy      = (phase != PH_IDLE);
   assign buf_ridx  = (phase == PH_DAT) ? idx + 1'b1 : '0;
   assign data_tx   = kind_q[0] ? buf_rbyte : 8'h00;
   assign buf_we    = sh_done && (phase == PH_DAT) && !kind_q[0];
   assign buf_widx  = idx;
   assign buf_wbyte = sh_rx;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_IDLE;
         cs_n <= 1'b1; sh_start <= 1'b0; sh_tx <= '0; done <= 1'b0;
         opc_q <= '0; kind_q <= '0; addr_q <= '0; last_q <= '0;
         den_q <= 1'b0; idx <= '0; gap <= '0;
      end else begin
         done     <= 1'b0;
         sh_start <= 1'b0;
         case (phase)
            PH_IDLE: if (go) begin
               opc_q <= c_opcode; kind_q <= c_kind; addr_q <= c_addr;
               last_q <= c_last; den_q <= c_den;
               cs_n <= 1'b0; sh_start <= 1'b1;
               phase <= c_atomic ? PH_PRE : PH_OPC;
               sh_tx <= c_atomic ? c_prefix : c_opcode;
            end
            PH_PRE: if (sh_done) begin
               cs_n <= 1'b1; gap <= '0; phase <= PH_GAP;
            end
            PH_GAP: begin
               if (gap == GLAST) begin
                  cs_n <= 1'b0; sh_tx <= opc_q; sh_start <= 1'b1;
                  phase <= PH_OPC;
               end else gap <= gap + 1'b1;
            end
            PH_OPC, PH_ADR: if (sh_done) begin
               if (kind_q[1] && (phase == PH_OPC || idx != ALAST)) begin
                  idx    <= (phase == PH_OPC) ? '0 : idx + 1'b1;
                  sh_tx  <= addr_q[23:16];
                  addr_q <= {addr_q[15:0], 8'h00};
                  sh_start <= 1'b1;
                  phase  <= PH_ADR;
               end else if (den_q) begin
                  idx <= '0; sh_tx <= data_tx; sh_start <= 1'b1;
                  phase <= PH_DAT;
               end else begin
                  cs_n <= 1'b1; done <= 1'b1; phase <= PH_IDLE;
               end
            end
            PH_DAT: if (sh_done) begin
               if (idx == last_q) begin
                  cs_n <= 1'b1; done <= 1'b1; phase <= PH_IDLE;
               end else begin
                  idx <= idx + 1'b1; sh_tx <= data_tx; sh_start <= 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assert_done_deselect_R6: assert property (@(posedge clk) disable iff (rst)
      done |-> cs_n);
   assert_go_starts_R6: assert property (@(posedge clk) disable iff (rst)
      go |=> busy);
endmodule

// File: rtl/spi_menu_regs.sv
module spi_menu_regs
   import spi_menu_pkg::*;
#(
   parameter int BUF_BYTES = 64,
   parameter int MENU_N    = 8,
   localparam int BW       = $clog2(BUF_BYTES)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          bus_wr,
   input  logic [5:0]    bus_addr,
   input  logic [1:0]    bus_be,
   input  logic [15:0]   bus_wdata,
   output logic [15:0]   bus_rdata,
   input  logic          seq_busy,
   input  logic          seq_done,
   input  logic          seq_we,
   input  logic [BW-1:0] seq_widx,
   input  logic [7:0]    seq_wbyte,
   input  logic [BW-1:0] seq_ridx,
   output logic [7:0]    seq_rbyte,
   output logic          go,
   output logic [7:0]    c_opcode,
   output logic [1:0]    c_kind,
   output logic [23:0]   c_addr,
   output logic [BW-1:0] c_last,
   output logic          c_den,
   output logic          c_atomic,
   output logic [7:0]    c_prefix
);
   generate
      if (BUF_BYTES < 4 || BUF_BYTES > 64 || (1 << BW) != BUF_BYTES) begin : g_bad_buf
         $error("BUF_BYTES must be a power of two from 4 to 64");
      end
      if (MENU_N != 8) begin : g_bad_menu
         $error("the 3-bit index field needs MENU_N of 8");
      end
   endgenerate

   logic [MENU_N-1:0][7:0] menu_q;
   logic [15:0]            kind_q, pref_q, ctl_q;
   logic [23:0]            addr_q;
   logic                   done_q, err_q, lock_q;
   logic [7:0]             buf_q [BUF_BYTES];

   logic          ctl_hit, go_req, stat_hit, cfg_ok;
   logic [2:0]    c_idx;
   logic [BW-2:0] wi;

   assign wi       = bus_addr[BW-2:0];
   assign ctl_hit  = bus_wr && bus_addr == A_CTRL;
   assign stat_hit = bus_wr && bus_addr == A_STAT && bus_be[0];
   assign go_req   = ctl_hit && bus_be[0] && bus_wdata[1];
   assign go       = go_req && !seq_busy;
   assign cfg_ok   = bus_wr && !lock_q;

   assign c_idx    = bus_wdata[6:4];
   assign c_opcode = menu_q[c_idx];
   assign c_kind   = kind_q[{c_idx, 1'b0} +: 2];
   assign c_addr   = addr_q;
   assign c_atomic = bus_wdata[2];
   assign c_prefix = bus_wdata[3] ? pref_q[15:8] : pref_q[7:0];
   assign c_last   = bus_be[1] ? bus_wdata[8 +: BW] : ctl_q[8 +: BW];
   assign c_den    = bus_be[1] ? bus_wdata[14]      : ctl_q[14];

   always_ff @(posedge clk) begin
      if (rst) begin
         menu_q <= '0; kind_q <= '0; pref_q <= '0; ctl_q <= '0; addr_q <= '0;
         done_q <= 1'b0; err_q <= 1'b0; lock_q <= 1'b0;
      end else begin
         if (ctl_hit && bus_be[0]) ctl_q[7:0]  <= bus_wdata[7:0] & 8'hFD;
         if (ctl_hit && bus_be[1]) ctl_q[15:8] <= bus_wdata[15:8];
         if (bus_wr && bus_addr == A_ADRL) begin
            if (bus_be[0]) addr_q[7:0]  <= bus_wdata[7:0];
            if (bus_be[1]) addr_q[15:8] <= bus_wdata[15:8];
         end
         if (bus_wr && bus_addr == A_ADRH && bus_be[0]) addr_q[23:16] <= bus_wdata[7:0];
         if (cfg_ok && bus_addr == A_PREF) begin
            if (bus_be[0]) pref_q[7:0]  <= bus_wdata[7:0];
            if (bus_be[1]) pref_q[15:8] <= bus_wdata[15:8];
         end
         if (cfg_ok && bus_addr == A_KIND) begin
            if (bus_be[0]) kind_q[7:0]  <= bus_wdata[7:0];
            if (bus_be[1]) kind_q[15:8] <= bus_wdata[15:8];
         end
         if (cfg_ok && bus_addr[5:2] == A_MENU) begin
            if (bus_be[0]) menu_q[{bus_addr[1:0], 1'b0}] <= bus_wdata[7:0];
            if (bus_be[1]) menu_q[{bus_addr[1:0], 1'b1}] <= bus_wdata[15:8];
         end
         if (bus_wr && bus_addr == A_STAT && bus_be[1] && bus_wdata[15]) lock_q <= 1'b1;
         if (seq_done)                          done_q <= 1'b1;
         else if (stat_hit && bus_wdata[2])     done_q <= 1'b0;
         if (go_req && seq_busy)                err_q <= 1'b1;
         else if (stat_hit && bus_wdata[3])     err_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (bus_wr && bus_addr[5]) begin
         if (bus_be[0]) buf_q[{wi, 1'b0}] <= bus_wdata[7:0];
         if (bus_be[1]) buf_q[{wi, 1'b1}] <= bus_wdata[15:8];
      end
      if (seq_we) buf_q[seq_widx] <= seq_wbyte;
   end

   assign seq_rbyte = buf_q[seq_ridx];

   always_comb begin
      bus_rdata = '0;
      if (bus_addr[5]) bus_rdata = {buf_q[{wi, 1'b1}], buf_q[{wi, 1'b0}]};
      else if (bus_addr[5:2] == A_MENU)
         bus_rdata = {menu_q[{bus_addr[1:0], 1'b1}], menu_q[{bus_addr[1:0], 1'b0}]};
      else begin
         case (bus_addr)
            A_STAT:  bus_rdata = {lock_q, 11'd0, err_q, done_q, 1'b0, seq_busy};
            A_CTRL:  bus_rdata = ctl_q;
            A_ADRL:  bus_rdata = addr_q[15:0];
            A_ADRH:  bus_rdata = {8'h00, addr_q[23:16]};
            A_PREF:  bus_rdata = pref_q;
            A_KIND:  bus_rdata = kind_q;
            default: bus_rdata = '0;
         endcase
      end
   end

   assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      lock_q |=> lock_q);
   assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (rst)
      lock_q |=> ($stable(menu_q) && $stable(kind_q) && $stable(pref_q)));
   assert_hibyte_nogo_R8: assert property (@(posedge clk) disable iff (rst)
      (ctl_hit && !bus_be[0] && !seq_busy) |=> !seq_busy);
   assert_busy_go_err_R9: assert property (@(posedge clk) disable iff (rst)
      (go_req && seq_busy) |=> err_q);
endmodule

// File: rtl/spi_menu_engine.sv
module spi_menu_engine #(
   parameter int BUF_BYTES = 64,
   parameter int SCK_DIV   = 2
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        bus_wr,
   input  logic [5:0]  bus_addr,
   input  logic [1:0]  bus_be,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   output logic        spi_sck,
   output logic        spi_cs_n,
   output logic        spi_mosi,
   input  logic        spi_miso
);
   localparam int BW = $clog2(BUF_BYTES);

   generate
      if (SCK_DIV < 1) begin : g_bad_div
         $error("SCK_DIV must be at least 1");
      end
   endgenerate

   logic          go, busy, done, buf_we, sh_start, sh_done, den, atomic;
   logic [7:0]    opcode, prefix, rbyte, wbyte, sh_tx, sh_rx;
   logic [1:0]    kind;
   logic [23:0]   addr;
   logic [BW-1:0] last, ridx, widx;

   spi_menu_regs #(.BUF_BYTES(BUF_BYTES), .MENU_N(8)) u_regs (
      .clk, .rst, .bus_wr, .bus_addr, .bus_be, .bus_wdata, .bus_rdata,
      .seq_busy(busy), .seq_done(done), .seq_we(buf_we), .seq_widx(widx),
      .seq_wbyte(wbyte), .seq_ridx(ridx), .seq_rbyte(rbyte), .go,
      .c_opcode(opcode), .c_kind(kind), .c_addr(addr), .c_last(last),
      .c_den(den), .c_atomic(atomic), .c_prefix(prefix));

   spi_menu_seq #(.DIV(SCK_DIV), .BW(BW)) u_seq (
      .clk, .rst, .go, .c_opcode(opcode), .c_kind(kind), .c_addr(addr),
      .c_last(last), .c_den(den), .c_atomic(atomic), .c_prefix(prefix),
      .buf_ridx(ridx), .buf_rbyte(rbyte), .buf_we, .buf_widx(widx),
      .buf_wbyte(wbyte), .busy, .done, .cs_n(spi_cs_n), .sh_start,
      .sh_tx, .sh_done, .sh_rx);

   spi_menu_shift #(.DIV(SCK_DIV)) u_shift (
      .clk, .rst, .start(sh_start), .tx(sh_tx), .miso(spi_miso),
      .sck(spi_sck), .mosi(spi_mosi), .done(sh_done), .rx(sh_rx));

   assert_sck_framed_R10: assert property (@(posedge clk) disable iff (rst)
      spi_sck |-> !spi_cs_n);
endmodule

// File: tb/sim_spi_menu_engine.sv
module sim_spi_menu_engine;
   localparam int CLK_PERIOD = 10;
   localparam int DIV = 2;

   logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, spi_miso = 1'b0;
   logic [5:0] bus_addr = '0;
   logic [1:0] bus_be = '0;
   logic [15:0] bus_wdata = '0, bus_rdata;
   logic spi_sck, spi_cs_n, spi_mosi;

   always #(CLK_PERIOD / 2) clk = ~clk;

   spi_menu_engine #(.BUF_BYTES(64), .SCK_DIV(DIV)) u0 (
      .clk, .rst, .bus_wr, .bus_addr, .bus_be, .bus_wdata, .bus_rdata,
      .spi_sck, .spi_cs_n, .spi_mosi, .spi_miso);

   int checks = 0, errors = 0, cyc = 0, badc = 0, hrun = 0;
   int bitc = 0, nf = 0;
   bit run = 1'b0, ended = 1'b0;
   logic [7:0] shin = '0, tmp;
   logic [7:0] fb [0:7][0:79];
   int flen [0:7];
   logic [15:0] rv;

   function automatic logic [7:0] resp(int k);
      return 8'(k * 37 + 5);
   endfunction

   function automatic logic [15:0] ctl(int idx, int cnt, bit de, bit at, bit ps);
      return {1'b0, de, 6'(cnt), 1'b0, 3'(idx), ps, at, 1'b1, 1'b0};
   endfunction

   // flash-side model: response byte k of a frame is resp(k)
   always @(negedge spi_cs_n) begin
      bitc = 0; tmp = resp(0); spi_miso = tmp[7];
   end
   always @(negedge spi_sck) if (spi_cs_n === 1'b0) begin
      bitc++; tmp = resp(bitc / 8); spi_miso = tmp[7 - (bitc % 8)];
   end
   always @(posedge spi_sck) if (spi_cs_n === 1'b0) begin
      shin = {shin[6:0], spi_mosi};
      if (bitc % 8 == 7 && nf < 8 && bitc / 8 < 80) fb[nf][bitc / 8] = shin;
   end
   always @(posedge spi_cs_n) if (run) begin
      if (nf < 8) flen[nf] = bitc / 8;
      nf++;
   end

   // per-clock comparison against the mode-0 pin model
   always @(negedge clk) if (run) begin
      if (spi_sck && spi_cs_n) badc++;
      if (spi_sck) hrun++;
      else begin
         if (hrun != 0 && hrun != DIV) badc++;
         hrun = 0;
      end
   end

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         summary();
      end
   end

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [5:0] a, logic [15:0] d, logic [1:0] be);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = '0;
   endtask

   task automatic rd(logic [5:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_done();
      logic [15:0] s;
      s = '0;
      while (!s[2]) rd(6'd0, s);
   endtask

   task automatic chkb(int f, int p, logic [7:0] e, string tag);
      check(fb[f][p] === e, tag, int'(fb[f][p]), int'(e));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      nf = 0; run = 1'b1;
      rd(6'd0, rv);
      check(rv == 16'h0000, "R6 reset status", rv, 0);
      check(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R10 reset pins", {spi_cs_n, spi_sck}, 2);

      wr(6'd8, 16'h029F, 2'b11); wr(6'd9, 16'h0603, 2'b11);
      wr(6'd10, 16'hD820, 2'b11); wr(6'd11, 16'h0B05, 2'b11);
      wr(6'd5, 16'h8F6C, 2'b11); wr(6'd4, 16'h5006, 2'b11);
      wr(6'd2, 16'h3456, 2'b11); wr(6'd3, 16'h0012, 2'b01);

      // R8: high byte alone, low byte data has the start bit
      wr(6'd1, ctl(2, 3, 1, 0, 0), 2'b10);
      repeat (40) @(negedge clk);
      rd(6'd0, rv);
      check(rv[0] == 1'b0 && nf == 0, "R8 high byte write starts nothing", nf, 0);
      // low byte write starts with the stored high byte: read with address
      wr(6'd1, ctl(2, 3, 1, 0, 0), 2'b01);
      rd(6'd0, rv);
      check(rv[0] == 1'b1, "R6 busy during cycle", rv, 1);
      wait_done();
      repeat (2) @(negedge clk);
      check(nf == 1 && flen[0] == 8, "R2 read-with-address frame length", flen[0], 8);
      chkb(0, 0, 8'h03, "R1 opcode from entry 2");
      chkb(0, 1, 8'h12, "R2 address msb");
      chkb(0, 2, 8'h34, "R2 address mid");
      chkb(0, 3, 8'h56, "R2 address lsb");
      rd(6'd32, rv);
      check(rv == {resp(5), resp(4)}, "R3 read data little-endian", rv, {resp(5), resp(4)});
      rd(6'd33, rv);
      check(rv == {resp(7), resp(6)}, "R3 read data bytes 2,3", rv, {resp(7), resp(6)});
      rd(6'd0, rv);
      check(rv == 16'h0004, "R6 done set", rv, 4);
      wr(6'd0, 16'h0004, 2'b01);
      rd(6'd0, rv);
      check(rv == 16'h0000, "R6 done cleared by writing 1", rv, 0);

      // R5: atomic prefix (high half), write with address, 3 data bytes
      wr(6'd32, 16'hBBAA, 2'b11); wr(6'd33, 16'h00CC, 2'b11);
      wr(6'd2, 16'h0100, 2'b11); wr(6'd3, 16'h0000, 2'b01);
      nf = 0;
      wr(6'd1, ctl(1, 2, 1, 1, 1), 2'b11);
      wait_done(); wr(6'd0, 16'h0004, 2'b01);
      check(nf == 2 && flen[0] == 1 && flen[1] == 7, "R5 prefix in own frame", nf, 2);
      chkb(0, 0, 8'h50, "R5 prefix select high");
      chkb(1, 0, 8'h02, "R1 opcode entry 1");
      chkb(1, 1, 8'h00, "R2 write address msb");
      chkb(1, 2, 8'h01, "R2 write address mid");
      chkb(1, 4, 8'hAA, "R3 write data byte 0");
      chkb(1, 6, 8'hCC, "R3 write data byte 2");

      // R4 + R5: data enable clear with nonzero count, prefix low half
      nf = 0;
      wr(6'd1, ctl(0, 5, 0, 1, 0), 2'b11);
      wait_done(); wr(6'd0, 16'h0004, 2'b01);
      check(nf == 2 && flen[1] == 1, "R4 no data phase when disabled", flen[1], 1);
      chkb(0, 0, 8'h06, "R5 prefix select low");
      chkb(1, 0, 8'h9F, "R1 opcode entry 0");
      nf = 0;
      wr(6'd1, ctl(3, 0, 0, 0, 0), 2'b11);
      wait_done(); wr(6'd0, 16'h0004, 2'b01);
      check(nf == 1 && flen[0] == 1 && fb[0][0] == 8'h06, "R2 no address for kind 1", flen[0], 1);

      // R11 + R9: full 64-byte read, second start while busy
      nf = 0;
      wr(6'd1, ctl(0, 63, 1, 0, 0), 2'b11);
      repeat (100) @(negedge clk);
      wr(6'd1, ctl(3, 0, 0, 0, 0), 2'b11);
      rd(6'd0, rv);
      check(rv[3] && rv[0], "R9 error on start while busy", rv, 9);
      wait_done();
      repeat (2) @(negedge clk);
      check(nf == 1 && flen[0] == 65, "R11 64 data bytes, R9 one frame", flen[0], 65);
      rd(6'd63, rv);
      check(rv == {resp(64), resp(63)}, "R11 last buffer word", rv, {resp(64), resp(63)});
      rd(6'd32, rv);
      check(rv == {resp(2), resp(1)}, "R3 read without address from byte 0", rv, {resp(2), resp(1)});
      rd(6'd0, rv);
      check(rv == 16'h000C, "R9 status done and error", rv, 12);
      wr(6'd0, 16'h000C, 2'b01);
      rd(6'd0, rv);
      check(rv == 16'h0000, "R6 error cleared by writing 1", rv, 0);

      // R7: lock
      wr(6'd0, 16'h8000, 2'b10);
      wr(6'd8, 16'hFFFF, 2'b11); wr(6'd5, 16'h0000, 2'b11); wr(6'd4, 16'h0000, 2'b11);
      rd(6'd0, rv);
      check(rv == 16'h8000, "R7 lock bit reads back", rv, 16'h8000);
      rd(6'd8, rv);
      check(rv == 16'h029F, "R7 table frozen", rv, 16'h029F);
      rd(6'd5, rv);
      check(rv == 16'h8F6C, "R7 kind frozen", rv, 16'h8F6C);
      rd(6'd4, rv);
      check(rv == 16'h5006, "R7 prefix frozen", rv, 16'h5006);
      wr(6'd0, 16'h000C, 2'b11);
      rd(6'd0, rv);
      check(rv[15] == 1'b1, "R7 lock survives status write", rv, 16'h8000);

      check(badc == 0, "R10 mode-0 clock per-cycle model", badc, 0);
      summary();
   end
endmodule